// File: doc/BRIEF.md
# Byte-Wide Parallel Configuration Loader

This block loads a target programmable device over a byte-wide parallel slave port, using image data held in a word-wide flash. A one-cycle reconfiguration strobe, together with the start address of an image slot, starts a load. The loader first drives the target's active-low program line low for a fixed number of cycles. It then waits for the target to raise its INIT line. When INIT is high, it streams the image.

Streaming works as follows. The loader sends read requests with word addresses to a flash read controller, which answers each request with a data-valid pulse after several cycles. Each returned word is split into bytes, high byte first. The loader drives one byte to the target for each rising edge of a configuration clock, which it generates by dividing the system clock. A one-word prefetch register hides the flash latency. When no byte is ready, the configuration clock stays low, so the target never sees a clock edge without data.

The load ends normally when the target raises DONE. If INIT or DONE does not arrive within its time limit, the loader sets a sticky error flag and goes back to idle. A new accepted strobe clears that flag.

Top module: `cfg_loader`

## Requirements
- R1: After reset the loader is idle: `prog_n_o` is 1, and `busy_o`, `err_o`, `cclk_o` and `rd_req_o` are all 0.
- R2: A strobe on `reconf_i` while idle latches `slot_base_i`. From the next cycle, `prog_n_o` goes low for exactly PROG_CYC cycles. `busy_o` goes high in the same cycle that `prog_n_o` first goes low.
- R3: After the program pulse, no read request is issued and `cclk_o` stays low until `init_i` has been sampled high.
- R4: If `init_i` is not sampled high within INIT_TMO cycles after the program pulse, `err_o` rises and the loader returns to idle. `err_o` stays high until the next accepted strobe, and is 0 from the cycle after that strobe.
- R5: The first read request of a load carries the slot base as its address. Each later request carries the previous address plus one. A new request is never issued while an earlier one is still unanswered.
- R6: Each 16-bit flash word is presented as two bytes on `cdata_o`: bits 15:8 first, then bits 7:0. Words are presented in address order.
- R7: `cclk_o` is high for exactly 2 system cycles per pulse. `cdata_o` does not change while `cclk_o` is high, and does not change in the cycle before a rising edge of `cclk_o`.
- R8: When the next byte is not yet available, `cclk_o` stays low until it is, and no byte is skipped or repeated.
- R9: When `done_i` is sampled high while streaming, the loader returns to idle with `err_o` 0. From then on it issues no further read requests, and `cclk_o` is low from the second cycle on.
- R10: If `done_i` is not sampled high within DONE_TMO cycles of streaming, `err_o` rises and the loader returns to idle.
- R11: A strobe on `reconf_i` while busy is ignored: the program line is not pulsed again, and the slot address does not change.
- R12: When the flash answers within 6 cycles of a request, rising edges of `cclk_o` follow each other every 4 system cycles, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reconf_i | input | 1 | One-cycle strobe that starts a load |
| slot_base_i | input | ADDR_W | Word address of the image slot, latched with the strobe |
| prog_n_o | output | 1 | Active-low program/initialize line to the target |
| init_i | input | 1 | Target ready for data (high) |
| done_i | input | 1 | Target configuration complete (high) |
| rd_req_o | output | 1 | One-cycle read request to the flash controller |
| rd_addr_o | output | ADDR_W | Word address, valid while `rd_req_o` is high |
| rd_valid_i | input | 1 | One-cycle pulse: `rd_data_i` answers the outstanding request |
| rd_data_i | input | WORD_W | Flash word returned by the controller |
| cclk_o | output | 1 | Divided configuration clock to the target |
| cdata_o | output | 8 | Configuration byte to the target |
| busy_o | output | 1 | A load is in progress |
| err_o | output | 1 | Sticky timeout flag for INIT or DONE |

## Verification
The bound assertions check every cycle that:
- the program pulse has the right length, and it is not restarted by a strobe that arrives while the loader is busy;
- reads wait for INIT, start at the latched base, step by one, and are never overlapped;
- each configuration clock pulse is 2 cycles wide, and the data byte is held still around it;
- the loader is quiet while idle.

Only the bench scenarios can show the rest:
- the byte sequence, with high byte first and words in address order;
- the unbroken 4-cycle clock rhythm with a short flash latency;
- the stalls with a long latency;
- the two timeout paths, and the flag clearing on the next load.

// File: rtl/cfg_loader_pkg.sv
// Shared types for the parallel configuration loader.
// Assumes: nothing beyond IEEE 1800-2017.
package cfg_loader_pkg;

    // Sequencer phases of one load
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_PULSE = 2'd1,
        LD_WINIT = 2'd2,
        LD_FEED  = 2'd3
    } ld_state_t;

endpackage

// File: rtl/cfg_loader_seq.sv
// Load sequencer: accepts a strobe, pulses the program line, waits for INIT,
// enables streaming and ends on DONE or on a timeout.
// Assumes: init_i and done_i are already synchronous to clk.
module cfg_loader_seq
    import cfg_loader_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int PROG_CYC = 8,
    parameter int INIT_TMO = 64,
    parameter int DONE_TMO = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reconf_i,
    input  logic [ADDR_W-1:0] slot_base_i,
    input  logic              init_i,
    input  logic              done_i,
    output logic              prog_n_o,
    output logic              busy_o,
    output logic              err_o,
    output logic              feed_o,
    output logic [ADDR_W-1:0] base_o
);

    localparam int MAX_A = (PROG_CYC > INIT_TMO) ? PROG_CYC : INIT_TMO;
    localparam int MAX_C = (MAX_A > DONE_TMO) ? MAX_A : DONE_TMO;
    localparam int CNT_W = $clog2(MAX_C + 1);

    ld_state_t         state;
    logic [CNT_W-1:0]  tmr;
    logic [ADDR_W-1:0] base_q;
    logic              err_q;

    // Advance the load phases and their cycle timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LD_IDLE;
            tmr    <= '0;
            base_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                LD_IDLE: begin
                    if (reconf_i) begin
                        state  <= LD_PULSE;
                        tmr    <= '0;
                        base_q <= slot_base_i;
                        err_q  <= 1'b0;
                    end
                end
                LD_PULSE: begin
                    if (tmr == CNT_W'(PROG_CYC - 1)) begin
                        state <= LD_WINIT;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                LD_WINIT: begin
                    if (init_i) begin
                        state <= LD_FEED;
                        tmr   <= '0;
                    end else if (tmr == CNT_W'(INIT_TMO - 1)) begin
                        state <= LD_IDLE;
                        err_q <= 1'b1;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                LD_FEED: begin
                    if (done_i) begin
                        state <= LD_IDLE;
                    end else if (tmr == CNT_W'(DONE_TMO - 1)) begin
                        state <= LD_IDLE;
                        err_q <= 1'b1;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= LD_IDLE;
            endcase
        end
    end

    // Decode phase into the outward lines
    always_comb begin
        prog_n_o = (state != LD_PULSE);
        busy_o   = (state != LD_IDLE);
        feed_o   = (state == LD_FEED);
        err_o    = err_q;
        base_o   = base_q;
    end

endmodule

// File: rtl/cfg_loader_fetch.sv
// Word fetcher: keeps one flash word prefetched, with at most one read in
// flight; the address starts at the slot base and steps by one per request.
// Assumes: the flash controller answers every request with one rd_valid_i.
module cfg_loader_fetch #(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feed_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              take_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              pf_vld_o,
    output logic [WORD_W-1:0] pf_data_o
);

    logic [ADDR_W-1:0] addr_q;
    logic              inflight;
    logic              pf_vld;
    logic [WORD_W-1:0] pf_data;

    // Request when streaming, the slot is empty and nothing is in flight
    always_comb begin
        rd_req_o  = feed_i && !pf_vld && !inflight;
        rd_addr_o = addr_q;
        pf_vld_o  = pf_vld;
        pf_data_o = pf_data;
    end

    // Track the in-flight read, the prefetch slot and the next address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            inflight <= 1'b0;
            pf_vld   <= 1'b0;
            pf_data  <= '0;
        end else if (!feed_i) begin
            addr_q <= base_i;
            pf_vld <= 1'b0;
            if (rd_valid_i) begin
                inflight <= 1'b0;
            end
        end else begin
            if (rd_req_o) begin
                inflight <= 1'b1;
                addr_q   <= addr_q + 1'b1;
            end
            if (rd_valid_i && inflight) begin
                inflight <= 1'b0;
                pf_vld   <= 1'b1;
                pf_data  <= rd_data_i;
            end
            if (take_i) begin
                pf_vld <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfg_loader_ser.sv
// Byte serializer and clock divider: splits words most significant byte
// first and drives one byte per divided clock period; the byte changes only
// at the start of a period, while the clock is low.
// Assumes: WORD_W is a multiple of 8; HALF_PER >= 1.
module cfg_loader_ser #(
    parameter int WORD_W   = 16,
    parameter int HALF_PER = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feed_i,
    input  logic              pf_vld_i,
    input  logic [WORD_W-1:0] pf_data_i,
    output logic              take_o,
    output logic              cclk_o,
    output logic [7:0]        cdata_o
);

    localparam int BPW   = WORD_W / 8;
    localparam int LFT_W = $clog2(BPW + 1);
    localparam int PER   = 2 * HALF_PER;
    localparam int PH_W  = $clog2(PER);

    logic [PH_W-1:0]   phase;
    logic              run;
    logic [WORD_W-1:0] cur;
    logic [LFT_W-1:0]  left;
    logic [7:0]        byte_q;
    logic              new_per;

    // A fresh period may start when stopped or on the last phase
    always_comb begin
        new_per = !run || (phase == PH_W'(PER - 1));
        take_o  = feed_i && new_per && (left == '0) && pf_vld_i;
        cclk_o  = run && (phase >= PH_W'(HALF_PER));
        cdata_o = byte_q;
    end

    // Step the divider and load the next byte at each period start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= '0;
            run    <= 1'b0;
            cur    <= '0;
            left   <= '0;
            byte_q <= '0;
        end else if (!feed_i) begin
            phase <= '0;
            run   <= 1'b0;
            left  <= '0;
        end else if (new_per) begin
            phase <= '0;
            if (left != '0) begin
                byte_q <= cur[WORD_W-1 -: 8];
                cur    <= cur << 8;
                left   <= left - 1'b1;
                run    <= 1'b1;
            end else if (pf_vld_i) begin
                byte_q <= pf_data_i[WORD_W-1 -: 8];
                cur    <= pf_data_i << 8;
                left   <= LFT_W'(BPW - 1);
                run    <= 1'b1;
            end else begin
                run <= 1'b0;
            end
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_loader.sv
// Top of the parallel slave configuration loader: sequencer, word fetcher
// and byte serializer.
// Assumes: one flash controller with a request/valid read port; target
// INIT and DONE lines synchronised to clk outside this block.
module cfg_loader #(
    parameter int ADDR_W   = 24,
    parameter int WORD_W   = 16,
    parameter int HALF_PER = 2,
    parameter int PROG_CYC = 8,
    parameter int INIT_TMO = 64,
    parameter int DONE_TMO = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reconf_i,
    input  logic [ADDR_W-1:0] slot_base_i,
    output logic              prog_n_o,
    input  logic              init_i,
    input  logic              done_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              cclk_o,
    output logic [7:0]        cdata_o,
    output logic              busy_o,
    output logic              err_o
);

    logic              feed;
    logic [ADDR_W-1:0] base;
    logic              take;
    logic              pf_vld;
    logic [WORD_W-1:0] pf_data;

    cfg_loader_seq #(
        .ADDR_W  (ADDR_W),
        .PROG_CYC(PROG_CYC),
        .INIT_TMO(INIT_TMO),
        .DONE_TMO(DONE_TMO)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .reconf_i   (reconf_i),
        .slot_base_i(slot_base_i),
        .init_i     (init_i),
        .done_i     (done_i),
        .prog_n_o   (prog_n_o),
        .busy_o     (busy_o),
        .err_o      (err_o),
        .feed_o     (feed),
        .base_o     (base)
    );

    cfg_loader_fetch #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .feed_i    (feed),
        .base_i    (base),
        .take_i    (take),
        .rd_req_o  (rd_req_o),
        .rd_addr_o (rd_addr_o),
        .rd_valid_i(rd_valid_i),
        .rd_data_i (rd_data_i),
        .pf_vld_o  (pf_vld),
        .pf_data_o (pf_data)
    );

    cfg_loader_ser #(
        .WORD_W  (WORD_W),
        .HALF_PER(HALF_PER)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .feed_i   (feed),
        .pf_vld_i (pf_vld),
        .pf_data_i(pf_data),
        .take_o   (take),
        .cclk_o   (cclk_o),
        .cdata_o  (cdata_o)
    );

endmodule

// File: rtl/cfg_loader_chk.sv
// Protocol checker for cfg_loader, bound to every instance.
// Assumes: observes ports only; keeps its own small trackers.
module cfg_loader_chk #(
    parameter int ADDR_W   = 24,
    parameter int HALF_PER = 2,
    parameter int PROG_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reconf_i,
    input logic [ADDR_W-1:0] slot_base_i,
    input logic              prog_n_o,
    input logic              init_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_valid_i,
    input logic              cclk_o,
    input logic [7:0]        cdata_o,
    input logic              busy_o,
    input logic              err_o
);

    logic              pend;
    logic              init_seen;
    logic              have_prev;
    logic [ADDR_W-1:0] prev_a;
    logic [ADDR_W-1:0] base_l;
    logic [15:0]       low_cnt;
    logic [15:0]       hi_cnt;

    // Trackers for read flow, INIT, addresses and pulse widths
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            init_seen <= 1'b0;
            have_prev <= 1'b0;
            prev_a    <= '0;
            base_l    <= '0;
            low_cnt   <= '0;
            hi_cnt    <= '0;
        end else begin
            if (rd_req_o) begin
                pend <= 1'b1;
            end else if (rd_valid_i) begin
                pend <= 1'b0;
            end
            if (!busy_o || !prog_n_o) begin
                init_seen <= 1'b0;
            end else if (init_i) begin
                init_seen <= 1'b1;
            end
            if (!busy_o) begin
                have_prev <= 1'b0;
            end else if (rd_req_o) begin
                have_prev <= 1'b1;
                prev_a    <= rd_addr_o;
            end
            if (reconf_i && !busy_o) begin
                base_l <= slot_base_i;
            end
            low_cnt <= prog_n_o ? 16'd0 : low_cnt + 16'd1;
            hi_cnt  <= cclk_o ? hi_cnt + 16'd1 : 16'd0;
        end
    end

    // R2: program pulse is exactly PROG_CYC cycles
    a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_n_o) |-> (low_cnt == 16'(PROG_CYC)));

    // R3: no read before INIT has been seen
    a_r3_wait_init: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> init_seen);

    // R5: never a second read while one is unanswered
    a_r5_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !pend);

    // R5: first address is the latched base
    a_r5_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !have_prev) |-> (rd_addr_o == base_l));

    // R5: later addresses step by one
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && have_prev) |-> (rd_addr_o == prev_a + 1'b1));

    // R7: byte held while the configuration clock is high
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_o |-> $stable(cdata_o));

    // R7: high phase width while a load is active
    a_r7_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cclk_o) && busy_o) |-> (hi_cnt == 16'(HALF_PER)));

    // R4 and R10: an error is only raised on the way back to idle
    a_r4_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o);

    // R9: idle means no program pulse and no reads
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (prog_n_o && !rd_req_o));

    // R11: a strobe while busy never restarts the program pulse
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (reconf_i && busy_o && prog_n_o) |=> prog_n_o);

endmodule

bind cfg_loader cfg_loader_chk #(
    .ADDR_W  (ADDR_W),
    .HALF_PER(HALF_PER),
    .PROG_CYC(PROG_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reconf_i   (reconf_i),
    .slot_base_i(slot_base_i),
    .prog_n_o   (prog_n_o),
    .init_i     (init_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .cclk_o     (cclk_o),
    .cdata_o    (cdata_o),
    .busy_o     (busy_o),
    .err_o      (err_o)
);

// File: tb/sim_cfg_loader.sv
// Bench for cfg_loader: behavioural model of the load phases, flash
// responder with programmable latency and byte-stream scoreboard.
module sim_cfg_loader;

    localparam int AW   = 24;
    localparam int WW   = 16;
    localparam int PCYC = 6;
    localparam int ITMO = 40;
    localparam int DTMO = 600;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reconf = 1'b0;
    logic [AW-1:0] slot = '0;
    logic          init = 1'b0;
    logic          done = 1'b0;
    logic          rd_valid = 1'b0;
    logic [WW-1:0] rd_data = '0;
    logic          prog_n_o, rd_req_o, cclk_o, busy_o, err_o;
    logic [AW-1:0] rd_addr_o;
    logic [7:0]    cdata_o;

    int nchk = 0;
    int nerr = 0;
    int lat = 3;
    bit nostall = 1'b0;
    bit finished = 1'b0;

    // model state: 0 idle, 1 pulse, 2 wait INIT, 3 streaming
    int m_st = 0;
    int m_cnt = 0;
    bit m_err = 1'b0;
    int m_base = 0;

    int kb = 0;
    int nreq = 0;
    int cyc = 0;
    int last_rise = 0;
    int max_gap = 0;

    always #2 clk = ~clk;

    cfg_loader #(
        .ADDR_W(AW), .WORD_W(WW), .HALF_PER(2),
        .PROG_CYC(PCYC), .INIT_TMO(ITMO), .DONE_TMO(DTMO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .reconf_i(reconf), .slot_base_i(slot),
        .prog_n_o(prog_n_o), .init_i(init), .done_i(done),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid), .rd_data_i(rd_data),
        .cclk_o(cclk_o), .cdata_o(cdata_o), .busy_o(busy_o), .err_o(err_o)
    );

    function automatic logic [15:0] flash_word(int a);
        return 16'(a * 40503 + 4660);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(int a);
        slot = AW'(a);
        reconf = 1'b1;
        @(negedge clk);
        reconf = 1'b0;
    endtask

    // Behavioural reference of the load phases
    initial forever begin
        @(posedge clk);
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_err = 1'b0; m_base = 0;
        end else begin
            case (m_st)
                0: if (reconf) begin m_st = 1; m_cnt = 0; m_base = int'(slot); m_err = 1'b0; end
                1: begin m_cnt++; if (m_cnt == PCYC) begin m_st = 2; m_cnt = 0; end end
                2: if (init) begin m_st = 3; m_cnt = 0; end
                   else begin m_cnt++; if (m_cnt == ITMO) begin m_st = 0; m_err = 1'b1; end end
                default: if (done) m_st = 0;
                   else begin m_cnt++; if (m_cnt == DTMO) begin m_st = 0; m_err = 1'b1; end end
            endcase
        end
    end

    // Per-cycle comparison of control outputs and the byte stream
    initial begin
        bit prev_c = 1'b0;
        logic [7:0] prev_d = '0;
        int hi = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(prog_n_o == (m_st != 1), "R2 prog_n", prog_n_o, m_st != 1);
                chk(busy_o == (m_st != 0), "R2 busy", busy_o, m_st != 0);
                chk(err_o == m_err, "R4/R10 err", err_o, m_err);
                if (m_st == 1 || m_st == 2) begin
                    chk(!cclk_o && !rd_req_o, "R3 quiet before INIT", {cclk_o, rd_req_o}, 0);
                end
                if (!prog_n_o) begin
                    kb = 0; max_gap = 0;
                end
                if (cclk_o && !prev_c) begin
                    logic [15:0] w;
                    w = flash_word(m_base + kb / 2);
                    chk(cdata_o == ((kb % 2 == 0) ? w[15:8] : w[7:0]), "R6 byte order",
                        cdata_o, (kb % 2 == 0) ? w[15:8] : w[7:0]);
                    chk(prev_d == cdata_o, "R7 setup before rise", cdata_o, prev_d);
                    if (kb > 0) begin
                        if (cyc - last_rise > max_gap) max_gap = cyc - last_rise;
                        if (nostall) chk(cyc - last_rise == 4, "R12 no stall period", cyc - last_rise, 4);
                    end
                    last_rise = cyc;
                    kb++;
                end
                if (cclk_o && prev_c) begin
                    chk(cdata_o == prev_d, "R7 hold while high", cdata_o, prev_d);
                end
                if (!cclk_o && prev_c && m_st == 3) begin
                    chk(hi == 2, "R7 high width", hi, 2);
                end
                hi = cclk_o ? hi + 1 : 0;
            end
            prev_c = cclk_o;
            prev_d = cdata_o;
        end
    end

    // Flash responder with latency lat, and read-request checks
    initial begin
        int cd = 0;
        int a = 0;
        bit pend = 1'b0;
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                rd_valid = 1'b0;
                pend = 1'b0;
            end
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    rd_valid = 1'b1;
                    rd_data = flash_word(a);
                end
            end
            if (!prog_n_o) nreq = 0;
            if (rd_req_o) begin
                chk(!pend, "R5 single outstanding", pend, 0);
                chk(int'(rd_addr_o) == ((m_base + nreq) & 24'hFFFFFF), "R5 address",
                    rd_addr_o, m_base + nreq);
                nreq++;
                a = int'(rd_addr_o);
                cd = lat;
                pend = 1'b1;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    // Scenarios
    initial begin
        int guard;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        chk(prog_n_o && !busy_o && !err_o && !cclk_o && !rd_req_o, "R1 reset state",
            {prog_n_o, busy_o, err_o, cclk_o, rd_req_o}, 5'b10000);

        // Load A: short latency, ignored strobe, ends on DONE
        lat = 3; nostall = 1'b1;
        strobe(24'h000100);
        chk(!prog_n_o && busy_o, "R2 pulse starts", {prog_n_o, busy_o}, 2'b01);
        while (!prog_n_o) tick(1);
        tick(5);
        chk(nreq == 0 && !cclk_o, "R3 no reads before INIT", nreq, 0);
        init = 1'b1;
        guard = 0;
        while (kb < 6 && guard < 2000) begin tick(1); guard++; end
        strobe(24'h000777);
        for (int i = 0; i < 10; i++) begin
            chk(prog_n_o, "R11 strobe while busy ignored", prog_n_o, 1);
            tick(1);
        end
        while (kb < 24 && guard < 4000) begin tick(1); guard++; end
        chk(kb >= 24, "R12 bytes streamed", kb, 24);
        done = 1'b1;
        tick(1);
        chk(!busy_o && !err_o, "R9 idle after DONE", {busy_o, err_o}, 0);
        done = 1'b0; init = 1'b0;
        tick(1);
        for (int i = 0; i < 12; i++) begin
            chk(!cclk_o && !rd_req_o, "R9 quiet after DONE", {cclk_o, rd_req_o}, 0);
            tick(1);
        end

        // Load B: long latency forces stalls, address carries past 0xFFFF
        lat = 14; nostall = 1'b0;
        strobe(24'h00FFFE);
        while (!prog_n_o) tick(1);
        tick(3);
        init = 1'b1;
        guard = 0;
        while (kb < 10 && guard < 4000) begin tick(1); guard++; end
        chk(kb >= 10, "R8 bytes after stalls", kb, 10);
        chk(max_gap > 4, "R8 clock held during stall", max_gap, 5);
        done = 1'b1;
        tick(1);
        done = 1'b0; init = 1'b0;
        tick(20);

        // INIT never arrives
        lat = 3;
        strobe(24'h000040);
        tick(PCYC + ITMO + 4);
        chk(err_o && !busy_o, "R4 INIT timeout", {err_o, busy_o}, 2'b10);
        tick(10);
        chk(err_o, "R4 error sticky", err_o, 1);

        // DONE never arrives
        strobe(24'h000200);
        chk(!err_o, "R4 error cleared by new load", err_o, 0);
        while (!prog_n_o) tick(1);
        init = 1'b1;
        guard = 0;
        while (busy_o && guard < 2000) begin tick(1); guard++; end
        chk(err_o && !busy_o, "R10 DONE timeout", {err_o, busy_o}, 2'b10);
        chk(kb > 0, "R10 stream ran before timeout", kb, 1);
        init = 1'b0;
        tick(10);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule